// File: doc/BRIEF.md
# Load Diagnostic Sequencer with Interrupt

This block turns raw fault comparator flags from two high-side load drivers and one thermal sensor into a latched eight-bit diagnostic byte. A run begins when the start-diagnostic status bit is high. A run is either a test-mode run or a normal-operation run. The kind of run decides which faults are examined and how the byte is laid out. A fault is recorded only if its flag stays high, without a single low cycle, for a window of `WIN_CYC` system clock cycles that begins when the run starts. The fault inputs pass through two-flop synchronizers first.

When a run completes, the result is held until the surrounding register interface strobes `read_done_i`. That strobe asks for the start bit to be cleared. If any warning bit (d6 to d0) of the byte changed with the run, the block drives an active-high pull-down enable for the open-drain interrupt line. At the same time it asks for the start bit to be set. The same read strobe releases the interrupt. A normal-operation run needs both drivers to be enabled. When that is not so, the request is dropped, the start bit is cleared and the byte stays as it was.

Top module: `load_diag_seq`

## Requirements
- R1: After reset, `diag_o` is 0x00, `irq_pd_o` is 0, and `start_set_o` and `start_clr_o` are 0.
- R2: In a normal-operation run (`test_mode_i`=0 when the run starts), d7=0, d6 = driver 1 overcurrent, d3 = driver 2 overcurrent, d0 = thermal warning, and d5, d4, d2, d1 are 0.
- R3: In a test-mode run (`test_mode_i`=1 when the run starts), d7=1, d5/d4 = driver 1 open load / short to supply, d2/d1 = the same two for driver 2, d0 = thermal warning, and d6, d3 are 0.
- R4: A fault bit is 1 only if the synchronized flag is high on every one of the `WIN_CYC` window cycles. Any single low cycle inside the window records 0.
- R5: `diag_o` changes only at the end of a run, exactly `WIN_CYC` clock cycles after the edge on which the run starts. It is unchanged one cycle before that.
- R6: A run request with `test_mode_i`=0 while either driver enable is low is aborted. `start_clr_o` pulses, `diag_o` is unchanged and no interrupt is raised.
- R7: After a completed run, a `read_done_i` strobe produces a one-cycle `start_clr_o` pulse. No pulse appears before the read.
- R8: `irq_pd_o` rises at the end of a run when any of d6..d0 differs from its previous value. It stays low when only d7 changes or when nothing changes.
- R9: Every interrupt assertion comes with a one-cycle `start_set_o` pulse in the same cycle. There is no pulse otherwise.
- R10: `read_done_i` releases `irq_pd_o` on the next clock edge.
- R11: The run mode and the driver enables are sampled when the run starts. Changing them during the window has no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| oc1_i | input | 1 | Driver 1 overcurrent flag (asynchronous) |
| ol1_i | input | 1 | Driver 1 open-load flag (asynchronous) |
| sb1_i | input | 1 | Driver 1 short-to-supply flag (asynchronous) |
| oc2_i | input | 1 | Driver 2 overcurrent flag (asynchronous) |
| ol2_i | input | 1 | Driver 2 open-load flag (asynchronous) |
| sb2_i | input | 1 | Driver 2 short-to-supply flag (asynchronous) |
| thr_i | input | 1 | Thermal warning flag (asynchronous) |
| test_mode_i | input | 1 | Test-mode status bit |
| start_i | input | 1 | Start-diagnostic status bit |
| drv1_en_i | input | 1 | Driver 1 enabled |
| drv2_en_i | input | 1 | Driver 2 enabled |
| read_done_i | input | 1 | One-cycle strobe: diagnostic byte has been read |
| diag_o | output | 8 | Latched diagnostic byte |
| start_set_o | output | 1 | One-cycle request to set the start bit |
| start_clr_o | output | 1 | One-cycle request to clear the start bit |
| irq_pd_o | output | 1 | Pull-down enable for the open-drain interrupt line |

## Verification
Counted from the edge on which the block sees `start_i` high, the result byte, the interrupt and the set pulse are all due `WIN_CYC` edges later. The bench checks the byte one cycle before that edge, expecting the old value, and on that edge, expecting the new one. An abort shows up as a clear pulse one edge after the request. A read strobe clears the interrupt and, for a pending result, pulses the clear request one edge after it is taken. The bench drives all inputs and samples all outputs on falling edges. It steps one cycle at a time, so each one-cycle pulse is seen exactly once. A glitch is placed so that its synchronized low cycle, two edges later, falls inside the window.

// File: rtl/lds_pkg.sv
package lds_pkg;
  localparam int unsigned NUM_FLAGS = 7;
  // flag vector positions
  localparam int unsigned F_OC1 = 0;
  localparam int unsigned F_OL1 = 1;
  localparam int unsigned F_SB1 = 2;
  localparam int unsigned F_OC2 = 3;
  localparam int unsigned F_OL2 = 4;
  localparam int unsigned F_SB2 = 5;
  localparam int unsigned F_THR = 6;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_HOLD = 2'd2
  } lds_state_e;

  // Byte layout is decoded by software; positions are fixed.
  function automatic logic [7:0] pack_diag(input logic test_run,
                                           input logic [NUM_FLAGS-1:0] hit);
    logic [7:0] d;
    d = '0;
    d[7] = test_run;
    d[0] = hit[F_THR];
    if (test_run) begin
      d[5] = hit[F_OL1];
      d[4] = hit[F_SB1];
      d[2] = hit[F_OL2];
      d[1] = hit[F_SB2];
    end else begin
      d[6] = hit[F_OC1];
      d[3] = hit[F_OC2];
    end
    return d;
  endfunction
endpackage

// File: rtl/lds_sync.sv
module lds_sync #(
  parameter int unsigned WIDTH = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/lds_persist.sv
module lds_persist #(
  parameter int unsigned WIN_CYC = 25000,
  localparam int unsigned CW = $clog2(WIN_CYC + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic flag_i,
  output logic held_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (!run_i || !flag_i) begin
      cnt_q <= '0;
    end else if (cnt_q != CW'(WIN_CYC)) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // high now and on every earlier window cycle
  assign held_o = flag_i && (cnt_q == CW'(WIN_CYC - 1));

  p_restart_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flag_i |=> (cnt_q == '0));
  p_bound_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(WIN_CYC));
endmodule

// File: rtl/lds_irq.sv
module lds_irq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic change_i,
  input  logic read_i,
  output logic irq_o,
  output logic set_o
);
  logic irq_q, set_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q <= 1'b0;
      set_q <= 1'b0;
    end else begin
      set_q <= change_i;
      if (change_i)    irq_q <= 1'b1;
      else if (read_i) irq_q <= 1'b0;
    end
  end

  assign irq_o = irq_q;
  assign set_o = set_q;

  p_set_has_irq_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_o |-> irq_o);
  p_release_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (read_i && !change_i) |=> !irq_o);
endmodule

// File: rtl/load_diag_seq.sv
module load_diag_seq
  import lds_pkg::*;
#(
  parameter int unsigned WIN_CYC = 25000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       oc1_i,
  input  logic       ol1_i,
  input  logic       sb1_i,
  input  logic       oc2_i,
  input  logic       ol2_i,
  input  logic       sb2_i,
  input  logic       thr_i,
  input  logic       test_mode_i,
  input  logic       start_i,
  input  logic       drv1_en_i,
  input  logic       drv2_en_i,
  input  logic       read_done_i,
  output logic [7:0] diag_o,
  output logic       start_set_o,
  output logic       start_clr_o,
  output logic       irq_pd_o
);
  localparam int unsigned WCW = $clog2(WIN_CYC);
  localparam logic [WCW-1:0] LAST = WCW'(WIN_CYC - 1);

  logic [NUM_FLAGS-1:0] raw, flg, held;
  lds_state_e  state_q;
  logic [WCW-1:0] wc_q;
  logic        mode_q, clr_q, run, fin, bad_req, chg;
  logic [7:0]  diag_q, new_diag;

  always_comb begin
    raw        = '0;
    raw[F_OC1] = oc1_i;
    raw[F_OL1] = ol1_i;
    raw[F_SB1] = sb1_i;
    raw[F_OC2] = oc2_i;
    raw[F_OL2] = ol2_i;
    raw[F_SB2] = sb2_i;
    raw[F_THR] = thr_i;
  end

  lds_sync #(.WIDTH(NUM_FLAGS)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw),
    .q_o   (flg)
  );

  assign run = (state_q == ST_RUN);
  assign fin = run && (wc_q == LAST);

  for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
    lds_persist #(.WIN_CYC(WIN_CYC)) i_persist (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .run_i (run),
      .flag_i(flg[g]),
      .held_o(held[g])
    );
  end

  assign new_diag = pack_diag(mode_q, held);
  assign chg      = fin && (new_diag[6:0] != diag_q[6:0]);
  assign bad_req  = !test_mode_i && !(drv1_en_i && drv2_en_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      wc_q    <= '0;
      mode_q  <= 1'b0;
      diag_q  <= '0;
      clr_q   <= 1'b0;
    end else begin
      clr_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            if (bad_req) begin
              clr_q <= 1'b1;
            end else begin
              mode_q  <= test_mode_i;
              wc_q    <= '0;
              state_q <= ST_RUN;
            end
          end
        end
        ST_RUN: begin
          wc_q <= wc_q + 1'b1;
          if (fin) begin
            diag_q  <= new_diag;
            state_q <= ST_HOLD;
          end
        end
        ST_HOLD: begin
          if (read_done_i) begin
            clr_q   <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  lds_irq i_irq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .change_i(chg),
    .read_i  (read_done_i),
    .irq_o   (irq_pd_o),
    .set_o   (start_set_o)
  );

  assign diag_o      = diag_q;
  assign start_clr_o = clr_q;

  p_normal_layout_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !diag_o[7] |-> (diag_o[5:4] == 2'b00 && diag_o[2:1] == 2'b00));
  p_test_layout_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    diag_o[7] |-> (!diag_o[6] && !diag_o[3]));
  p_only_at_end_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(diag_o) |-> $past(fin));
  p_abort_keep_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && start_i && bad_req) |=>
      ($stable(diag_o) && start_clr_o && !$rose(irq_pd_o)));
  p_clear_on_read_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_HOLD && read_done_i) |=> start_clr_o);
  p_no_early_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run |=> !start_clr_o);
  p_irq_on_change_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_pd_o) |-> $past(fin));
  p_irq_sets_start_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_pd_o) |-> start_set_o);
  p_mode_held_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run |=> $stable(mode_q));
endmodule

// File: tb/test_load_diag_seq.sv
`timescale 1ns/1ps
module test_load_diag_seq;
  localparam int unsigned WIN = 20;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic [6:0] raw = '0;  // oc1 ol1 sb1 oc2 ol2 sb2 thr at bits 0..6
  logic test_mode_i = 1'b0, start_i = 1'b0, drv1_en_i = 1'b0, drv2_en_i = 1'b0;
  logic read_done_i = 1'b0;
  logic [7:0] diag_o;
  logic start_set_o, start_clr_o, irq_pd_o;

  int n_chk = 0, n_fail = 0;
  int seen_clr, seen_set;
  logic [7:0] prev = 8'h00;

  always #2 clk_i = ~clk_i;

  load_diag_seq #(.WIN_CYC(WIN)) i_load_diag_seq (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .oc1_i(raw[0]), .ol1_i(raw[1]), .sb1_i(raw[2]),
    .oc2_i(raw[3]), .ol2_i(raw[4]), .sb2_i(raw[5]), .thr_i(raw[6]),
    .test_mode_i(test_mode_i), .start_i(start_i),
    .drv1_en_i(drv1_en_i), .drv2_en_i(drv2_en_i),
    .read_done_i(read_done_i), .diag_o(diag_o),
    .start_set_o(start_set_o), .start_clr_o(start_clr_o), .irq_pd_o(irq_pd_o)
  );

  function automatic logic [7:0] exp_diag(input logic tm, input logic [6:0] f);
    if (tm) return {1'b1, 1'b0, f[1], f[2], 1'b0, f[4], f[5], f[6]};
    return {1'b0, f[0], 2'b00, f[3], 2'b00, f[6]};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one cycle: wait for falling edge, observe pulses, model the status bit
  task automatic step();
    @(negedge clk_i);
    if (start_clr_o) begin seen_clr++; start_i = 1'b0; end
    else if (start_set_o) begin seen_set++; start_i = 1'b1; end
  endtask

  task automatic run(input logic tm, input logic e1, input logic e2,
                     input logic [6:0] f, input int gbit, input int gat,
                     input logic flip);
    logic bad;
    logic [6:0] fexp;
    logic [7:0] exp;
    logic chg;
    raw = f; test_mode_i = tm; drv1_en_i = e1; drv2_en_i = e2;
    repeat (4) step();
    seen_clr = 0; seen_set = 0;
    start_i = 1'b1;
    bad = !tm && !(e1 && e2);
    fexp = f;
    if (gbit >= 0) fexp[gbit] = 1'b0;
    exp = exp_diag(tm, fexp);
    chg = (exp[6:0] != prev[6:0]);
    for (int k = 0; k <= WIN + 3; k++) begin
      step();
      if (k == 0 && bad) chk("R6 abort clear pulse", seen_clr, 1);
      if (gbit >= 0 && k == gat) raw[gbit] = 1'b0;
      if (gbit >= 0 && k == gat + 1) raw[gbit] = f[gbit];
      if (flip && k == 3) begin
        test_mode_i = ~tm; drv1_en_i = 1'b0; drv2_en_i = 1'b0;
      end
      if (!bad && k == WIN - 1) chk("R5 unchanged before due", diag_o, prev);
      if (!bad && k == WIN) chk("R5 due edge R2 R3 R4 R11 layout", diag_o, exp);
    end
    test_mode_i = tm; drv1_en_i = e1; drv2_en_i = e2;
    if (bad) begin
      chk("R6 byte unchanged", diag_o, prev);
      chk("R6 no interrupt", irq_pd_o, 0);
      start_i = 1'b0;
    end else begin
      chk("R8 interrupt on warning change", irq_pd_o, chg);
      chk("R9 set pulse with interrupt", seen_set, chg);
      chk("R7 no clear before read", seen_clr, 0);
      read_done_i = 1'b1;
      step();
      read_done_i = 1'b0;
      chk("R7 clear pulse after read", seen_clr, 1);
      chk("R10 interrupt released", irq_pd_o, 0);
      prev = exp;
    end
    step();
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240607));
    repeat (3) @(negedge clk_i);
    chk("R1 reset byte", diag_o, 0);
    chk("R1 reset irq", irq_pd_o, 0);
    chk("R1 reset pulses", {start_set_o, start_clr_o}, 0);
    rst_ni = 1'b1;
    step();
    // directed corners
    run(1'b0, 1'b1, 1'b1, 7'h7F, -1, 0, 1'b0);   // R2 all faults, normal
    run(1'b0, 1'b1, 1'b1, 7'h7F, -1, 0, 1'b0);   // R8 no change, no irq
    run(1'b1, 1'b1, 1'b1, 7'h7F, -1, 0, 1'b1);   // R3 test mode, R11 flip
    run(1'b0, 1'b1, 1'b0, 7'h00, -1, 0, 1'b0);   // R6 abort
    run(1'b0, 1'b0, 1'b1, 7'h01, -1, 0, 1'b0);   // R6 abort
    run(1'b0, 1'b1, 1'b1, 7'h00, -1, 0, 1'b0);   // clear all
    run(1'b1, 1'b0, 1'b0, 7'h00, -1, 0, 1'b0);   // R8 only d7 changes
    run(1'b1, 1'b1, 1'b1, 7'h12, 1, WIN - 4, 1'b0); // R4 late glitch
    run(1'b0, 1'b1, 1'b1, 7'h49, 6, 1, 1'b0);    // R4 early glitch
    run(1'b0, 1'b1, 1'b1, 7'h49, -1, 0, 1'b1);   // R11 flip mid-run
    for (int i = 0; i < 40; i++) begin
      logic tm, e1, e2, fl;
      logic [6:0] f;
      int gb, ga;
      tm = 1'($urandom);
      e1 = ($urandom % 4) != 0;
      e2 = ($urandom % 4) != 0;
      f  = 7'($urandom);
      fl = ($urandom % 5) == 0;
      gb = ($urandom % 3 == 0) ? int'($urandom % 7) : -1;
      ga = 1 + int'($urandom % (WIN - 4));
      run(tm, e1, e2, f, gb, ga, fl);
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule